// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a small global record of the outcomes of the last two branches executed, whatever their addresses. It also keeps a table of 2-bit saturating counters. A fetch address and the current global record together pick one counter, and that counter's upper bit is the prediction. Each address row therefore holds four counters, one for each pattern of the two preceding outcomes. The predictor can then learn branches whose direction depends on what nearby branches just did.

The fetch stage drives `pred_pc` and gets `pred_taken` back in the same cycle, with no register in that path. It also gets `pred_hist`, the global record used for that lookup, and carries it down the pipe with the branch. When the branch resolves, the back end presents the address, the carried history and the real outcome on the update port. The block trains that one counter and shifts the outcome into the global record. At most one update is accepted per cycle.

Each counter is a four-state machine: `CTR_SNT` (00, strongly not taken), `CTR_WNT` (01, weakly not taken), `CTR_WT` (10, weakly taken) and `CTR_ST` (11, strongly taken). A taken outcome makes the transitions SNT→WNT, WNT→WT, WT→ST and ST→ST. A not-taken outcome makes the transitions ST→WT, WT→WNT, WNT→SNT and SNT→SNT. With no training strobe a counter stays in its state.

Top module: `corr_bpred`

## Requirements
- R1: After reset `pred_hist` is 00, and every counter is in `CTR_WNT`, so `pred_taken` is 0 for every address.
- R2: `pred_taken` is combinational. It equals bit 1 of the counter in row `pred_pc[5:2]` at column `pred_hist`, and it follows a change of `pred_pc` within the same cycle.
- R3: On a clock edge with `upd_valid` high, the global history becomes {old bit 0, `upd_taken`}. The newest outcome lands in bit 0 and the older one moves to bit 1, so 01 means the earlier branch was not taken and the latest was taken.
- R4: A trained counter steps one state up on a taken outcome and one state down on a not-taken outcome. It saturates at 11 and at 00.
- R5: From `CTR_ST`, a single not-taken outcome leaves the prediction taken, and a second one turns it not taken. The opposite direction behaves the same way from `CTR_SNT`.
- R6: An update trains only the counter at row `upd_pc[5:2]` and column `upd_hist`. The other three counters of that row and all other rows keep their state.
- R7: Address bits outside [5:2] have no effect. Two addresses that share bits [5:2] use the same row for both prediction and update.
- R8: While `upd_valid` is low, no counter changes and the global history holds.
- R9: The column that is trained is taken from `upd_hist` and not from the current global history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W (32) | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W (2) | Global history used for this lookup |
| upd_valid | input | 1 | Resolved-branch strobe |
| upd_pc | input | PC_W (32) | Address of the resolved branch |
| upd_hist | input | HIST_W (2) | History carried from the branch's prediction |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A prediction is due in the same cycle its address is applied. The bench drives `pred_pc` just after a falling edge and samples `pred_taken` 1 ns later, before the next rising edge. An update takes effect at the single rising edge during which `upd_valid` is high. Both the new history and the new counter state can be seen from the falling edge that follows, and the bench checks them there against a model that tracks all counters and the history. To read a chosen column, the bench first steers the history with two updates to a scratch row, then samples the prediction in that same low phase.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WNT;

endpackage

// File: rtl/bp_ctr.sv
module bp_ctr
    import bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       train,
    input  logic       outcome,
    output ctr_state_e state_o,
    output logic       taken_o
);

    ctr_state_e state_q;
    ctr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (train) begin
            unique case (state_q)
                CTR_SNT: state_d = outcome ? CTR_WNT : CTR_SNT;
                CTR_WNT: state_d = outcome ? CTR_WT  : CTR_SNT;
                CTR_WT:  state_d = outcome ? CTR_ST  : CTR_WNT;
                CTR_ST:  state_d = outcome ? CTR_ST  : CTR_WT;
                default: state_d = CTR_RESET;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CTR_SNT, CTR_WNT: taken_o = 1'b0;
            CTR_WT,  CTR_ST:  taken_o = 1'b1;
            default:          taken_o = 1'b0;
        endcase
        state_o = state_q;
    end

endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= outcome;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], outcome};
            end
        end
    endgenerate

    assign hist_o = hist_q;

endmodule

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ROW_W-1:0]             rd_row,
    input  logic [HIST_W-1:0]            rd_hist,
    output logic                         rd_taken,
    input  logic                         wr_en,
    input  logic [ROW_W-1:0]             wr_row,
    input  logic [HIST_W-1:0]            wr_hist,
    input  logic                         wr_taken,
    output logic [2*(1<<(ROW_W+HIST_W))-1:0] all_state
);

    localparam int SEL_W = ROW_W + HIST_W;
    localparam int N_CTR = 1 << SEL_W;

    logic [SEL_W-1:0] rd_sel;
    logic [SEL_W-1:0] wr_sel;
    logic [N_CTR-1:0] taken_vec;

    assign rd_sel = {rd_row, rd_hist};
    assign wr_sel = {wr_row, wr_hist};

    generate
        for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
            ctr_state_e st;
            bp_ctr u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .train   (wr_en && (wr_sel == SEL_W'(i))),
                .outcome (wr_taken),
                .state_o (st),
                .taken_o (taken_vec[i])
            );
            assign all_state[2*i +: 2] = st;
        end
    endgenerate

    assign rd_taken = taken_vec[rd_sel];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
    parameter int PC_W   = 32,
    parameter int ROW_W  = 4,
    parameter int HIST_W = 2,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken
);

    localparam int N_CTR = 1 << (ROW_W + HIST_W);

    logic [HIST_W-1:0]  ghr;
    logic [2*N_CTR-1:0] ctr_all;

    bp_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .outcome  (upd_taken),
        .hist_o   (ghr)
    );

    bp_table #(.ROW_W(ROW_W), .HIST_W(HIST_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_row    (pred_pc[PC_LSB +: ROW_W]),
        .rd_hist   (ghr),
        .rd_taken  (pred_taken),
        .wr_en     (upd_valid),
        .wr_row    (upd_pc[PC_LSB +: ROW_W]),
        .wr_hist   (upd_hist),
        .wr_taken  (upd_taken),
        .all_state (ctr_all)
    );

    assign pred_hist = ghr;

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
    parameter int PC_W   = 32,
    parameter int ROW_W  = 4,
    parameter int HIST_W = 2,
    parameter int PC_LSB = 2
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   upd_valid,
    input logic [PC_W-1:0]                        upd_pc,
    input logic [HIST_W-1:0]                      upd_hist,
    input logic                                   upd_taken,
    input logic [HIST_W-1:0]                      pred_hist,
    input logic [2*(1<<(ROW_W+HIST_W))-1:0]       ctr_all
);

    localparam int SEL_W = ROW_W + HIST_W;
    localparam int N_CTR = 1 << SEL_W;

    logic [SEL_W-1:0]   sel_now;
    logic [1:0]         old_now;
    logic [SEL_W-1:0]   last_sel;
    logic [2*N_CTR-1:0] last_all;
    logic [1:0]         cur_of_last;
    logic [2*N_CTR-1:0] keep_mask;

    assign sel_now     = {upd_pc[PC_LSB +: ROW_W], upd_hist};
    assign old_now     = ctr_all[2*sel_now +: 2];
    assign cur_of_last = ctr_all[2*last_sel +: 2];
    assign keep_mask   = ~({{(2*N_CTR-2){1'b0}}, 2'b11} << (2*last_sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_sel <= '0;
            last_all <= '0;
        end else begin
            last_sel <= sel_now;
            last_all <= ctr_all;
        end
    end

    // R3: history shift order
    p_hist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_hist == {$past(pred_hist[0]), $past(upd_taken)});

    // R8: idle cycle leaves everything alone
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(pred_hist) && $stable(ctr_all)));

    // R4: taken step with saturation
    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
        cur_of_last == (($past(old_now) == 2'b11) ? 2'b11 : $past(old_now) + 2'd1));

    // R4: not-taken step with saturation
    p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=>
        cur_of_last == (($past(old_now) == 2'b00) ? 2'b00 : $past(old_now) - 2'd1));

    // R6, R9: only the addressed counter moves
    p_only_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ((ctr_all ^ last_all) & keep_mask) == '0);

endmodule

bind corr_bpred corr_bpred_chk #(
    .PC_W(PC_W), .ROW_W(ROW_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_hist  (upd_hist),
    .upd_taken (upd_taken),
    .pred_hist (pred_hist),
    .ctr_all   (ctr_all)
);

// File: tb/corr_bpred_tb_top.sv
`timescale 1ns/1ps
module corr_bpred_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [1:0]  pred_hist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [1:0]  upd_hist = '0;
    logic        upd_taken = 1'b0;

    int total = 0;
    int bad = 0;

    logic [1:0] m_ctr [64];
    logic [1:0] m_ghr;

    always #2 clk = ~clk;

    corr_bpred dut_i (
        .clk(clk), .rst_n(rst_n),
        .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist),
        .upd_taken(upd_taken)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one update, applied at the next rising edge; model follows
    task automatic upd(input logic [31:0] pc, input logic [1:0] h, input logic t);
        int idx;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
        idx = {pc[5:2], h};
        if (t) m_ctr[idx] = (m_ctr[idx] == 2'b11) ? 2'b11 : m_ctr[idx] + 2'd1;
        else   m_ctr[idx] = (m_ctr[idx] == 2'b00) ? 2'b00 : m_ctr[idx] - 2'd1;
        m_ghr = {m_ghr[0], t};
        chk("R3 history", {30'd0, pred_hist}, {30'd0, m_ghr});
    endtask

    // set global history via scratch row 15
    task automatic steer(input logic [1:0] h);
        upd(32'h3C, 2'b11, h[1]);
        upd(32'h3C, 2'b11, h[0]);
    endtask

    // read prediction of row r at history h, compare with model
    task automatic probe(input logic [31:0] pc, input logic [1:0] h, input string req);
        steer(h);
        pred_pc = pc;
        #1;
        chk(req, {31'd0, pred_taken}, {31'd0, m_ctr[{pc[5:2], h}][1]});
    endtask

    task automatic t_reset;
        chk("R1 history", {30'd0, pred_hist}, 32'd0);
        for (int r = 0; r < 16; r++) begin
            pred_pc = 32'(r) << 2;
            #0.1;
            chk("R1 weak not taken", {31'd0, pred_taken}, 32'd0);
        end
    endtask

    task automatic t_counter;
        logic [31:0] pc = 32'h0C; // row 3
        upd(pc, 2'b00, 1'b1); probe(pc, 2'b00, "R4 WNT to WT");
        chk("R4 predicts taken", {31'd0, pred_taken}, 32'd1);
        upd(pc, 2'b00, 1'b1); upd(pc, 2'b00, 1'b1); upd(pc, 2'b00, 1'b1);
        probe(pc, 2'b00, "R4 saturate high");
        upd(pc, 2'b00, 1'b0); probe(pc, 2'b00, "R5 one miss keeps taken");
        chk("R5 still taken", {31'd0, pred_taken}, 32'd1);
        upd(pc, 2'b00, 1'b0); probe(pc, 2'b00, "R5 two misses flip");
        chk("R5 now not taken", {31'd0, pred_taken}, 32'd0);
        upd(pc, 2'b00, 1'b0); upd(pc, 2'b00, 1'b0); upd(pc, 2'b00, 1'b0);
        upd(pc, 2'b00, 1'b1); probe(pc, 2'b00, "R4 saturate low");
        chk("R5 one taken from SNT stays not taken", {31'd0, pred_taken}, 32'd0);
    endtask

    task automatic t_isolation;
        logic [31:0] pc = 32'h14; // row 5
        upd(pc, 2'b10, 1'b1); upd(pc, 2'b10, 1'b1);
        probe(pc, 2'b10, "R6 trained column");
        chk("R6 trained taken", {31'd0, pred_taken}, 32'd1);
        probe(pc, 2'b00, "R6 column 00 untouched");
        probe(pc, 2'b01, "R6 column 01 untouched");
        probe(pc, 2'b11, "R6 column 11 untouched");
        probe(32'h18, 2'b10, "R6 other row untouched");
        chk("R6 other row not taken", {31'd0, pred_taken}, 32'd0);
    endtask

    task automatic t_history_col;
        // current ghr differs from upd_hist; trained column must follow upd_hist
        steer(2'b11);
        upd(32'h20, 2'b01, 1'b1); upd(32'h20, 2'b01, 1'b1);
        probe(32'h20, 2'b01, "R9 column from upd_hist");
        chk("R9 taken", {31'd0, pred_taken}, 32'd1);
        probe(32'h20, 2'b11, "R9 current-history column untouched");
        chk("R9 not taken", {31'd0, pred_taken}, 32'd0);
        steer(2'b01);
        chk("R3 01 = older NT, newer T", {30'd0, pred_hist}, 32'd1);
    endtask

    task automatic t_alias;
        upd(32'hABC0_101C, 2'b10, 1'b1); upd(32'h0000_F01C, 2'b10, 1'b1);
        probe(32'h0000_001F, 2'b10, "R7 high and low bits ignored");
        chk("R7 aliased taken", {31'd0, pred_taken}, 32'd1);
        pred_pc = 32'h0000_0020;
        #0.5;
        chk("R2 same-cycle follow", {31'd0, pred_taken}, {31'd0, m_ctr[{4'd8, m_ghr}][1]});
    endtask

    task automatic t_idle;
        logic [1:0] h0;
        logic [31:0] pc = 32'h1C;
        pred_pc = pc;
        h0 = pred_hist;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            upd_pc = pc; upd_hist = h0; upd_taken = k[0];
        end
        @(negedge clk);
        #1;
        chk("R8 history held", {30'd0, pred_hist}, {30'd0, h0});
        chk("R8 counter held", {31'd0, pred_taken}, {31'd0, m_ctr[{pc[5:2], h0}][1]});
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
        m_ghr = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter();
        t_isolation();
        t_history_col();
        t_alias();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule